// File: doc/BRIEF.md
# Prefix-Extended Store Address Unit

This unit sits in the execute stage of a compact processor with 16-bit instructions and 24-bit general registers. It recognises one instruction: a word store that writes a register to memory through a 32-bit write port. Immediate-extension prefix instructions can come before the store. The unit collects their immediates and uses them as an address displacement. The unit drives the register-file read selects for the source and base registers and receives the two register values back. It then issues one registered memory write per accepted store.

The effective address is the base register plus a displacement, taken modulo 2^24. The displacement is zero when no prefix is pending. With one pending prefix it is that prefix's 13-bit immediate. With two prefixes it is a 24-bit value assembled from both. The written word carries the 24-bit source value with a zero top byte.

An address whose two low bits are not zero raises a misalignment exception request. The write still goes to the word address with those bits cleared. A store in the delay slot of a delayed branch ignores any pending prefix. Any instruction that is not a prefix empties the prefix state.

Top module: `store_addr_unit`

## Requirements
- R1: A valid instruction is a store when bits 15:10 are 001001 and bits 6:3 are 0011. Bits 9:7 select the source register on `rs_sel` and bits 2:0 select the base register on `rb_sel`. Any other pattern causes no write.
- R2: A store with no pending prefix writes to the base register value.
- R3: A store with one pending prefix writes to the base plus that prefix's 13-bit immediate. The immediate is zero-extended when SIGNED_DISP is 0 and sign-extended from bit 12 when SIGNED_DISP is 1.
- R4: With two pending prefixes, the low 11 bits of the earlier immediate form displacement bits 23:13 and the later immediate forms bits 12:0. The sum with the base wraps modulo 2^24.
- R5: The write data is the 24-bit source register value in bits 23:0, with bits 31:24 equal to zero.
- R6: When bits 1:0 of the computed address are non-zero, `misalign_req` is 1 with the write. The written address always has bits 1:0 cleared.
- R7: A store with `delay_slot` high uses the plain base address, whatever prefixes are pending, and empties the prefix state.
- R8: Any valid instruction that is not a prefix empties the prefix state. Cycles with `instr_valid` low leave it unchanged.
- R9: A prefix instruction has bits 15:13 equal to 110 and its immediate in bits 12:0. When more than two prefixes come in a row, only the last two count.
- R10: The write (`mem_we`, address, data and misalignment) appears in the cycle after the store is presented. `mem_we` is low in every other cycle.
- R11: In reset, `mem_we` and `misalign_req` are 0 and the prefix state is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| delay_slot | input | 1 | Instruction is in a delayed-branch slot |
| rs_sel | output | 3 | Source register select |
| rb_sel | output | 3 | Base register select |
| rs_val | input | 24 | Source register value |
| rb_val | input | 24 | Base register value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Word-aligned write address |
| mem_wdata | output | 32 | Write data |
| misalign_req | output | 1 | Misaligned-address exception request |

## Verification
The bench builds two copies of the unit side by side with the default 24-bit address. One copy has SIGNED_DISP at 0 and the other at 1. Every instruction sequence is applied to both copies. A single-prefix displacement with bit 12 set therefore shows, in the same cycle, both the forward reach of zero extension and the backward reach of sign extension. The two-prefix and wrap-around cases check that both settings agree when the full 24-bit displacement is formed.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int INSTR_W    = 16;
  localparam int PFX_IMM_W  = 13;
  localparam int REG_IDX_W  = 3;

  localparam logic [5:0] ST_MAJOR  = 6'b001001;
  localparam logic [3:0] ST_MINOR  = 4'b0011;
  localparam logic [2:0] PFX_MAJOR = 3'b110;

  typedef enum logic [1:0] {
    PFX_NONE = 2'd0,
    PFX_ONE  = 2'd1,
    PFX_TWO  = 2'd2
  } pfx_cnt_e;

  typedef struct packed {
    logic                  is_store;
    logic                  is_prefix;
    logic [REG_IDX_W-1:0]  rs;
    logic [REG_IDX_W-1:0]  rb;
    logic [PFX_IMM_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/sau_decode.sv
module sau_decode
  import sau_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec.is_store  = valid && (instr[15:10] == ST_MAJOR) && (instr[6:3] == ST_MINOR);
    dec.is_prefix = valid && (instr[15:13] == PFX_MAJOR);
    dec.rs        = instr[9:7];
    dec.rb        = instr[2:0];
    dec.imm       = instr[PFX_IMM_W-1:0];
  end
endmodule

// File: rtl/sau_prefix.sv
module sau_prefix
  import sau_pkg::*;
#(
  parameter int LO_W = 13,
  parameter int HI_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            is_prefix,
  input  logic [LO_W-1:0] imm,
  output pfx_cnt_e        cnt,
  output logic [LO_W-1:0] lo,
  output logic [HI_W-1:0] hi
);
  pfx_cnt_e        cnt_n;
  logic [LO_W-1:0] lo_n;
  logic [HI_W-1:0] hi_n;
  logic            en;

  assign en = valid;

  always_comb begin
    cnt_n = cnt;
    lo_n  = lo;
    hi_n  = hi;
    if (is_prefix) begin
      cnt_n = (cnt == PFX_NONE) ? PFX_ONE : PFX_TWO;
      hi_n  = lo[HI_W-1:0];
      lo_n  = imm;
    end else begin
      cnt_n = PFX_NONE;
      lo_n  = '0;
      hi_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= PFX_NONE;
      lo  <= '0;
      hi  <= '0;
    end else if (en) begin
      cnt <= cnt_n;
      lo  <= lo_n;
      hi  <= hi_n;
    end
  end

  p_consume_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !is_prefix) |=> (cnt == PFX_NONE));

  p_idle_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(cnt) && $stable(lo) && $stable(hi));

  p_chain_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_prefix && cnt != PFX_NONE) |=> (cnt == PFX_TWO));
endmodule

// File: rtl/sau_agen.sv
module sau_agen
  import sau_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LO_W        = 13,
  parameter int HI_W        = 11,
  parameter bit SIGNED_DISP = 1'b0
) (
  input  logic [ADDR_W-1:0] base,
  input  pfx_cnt_e          cnt,
  input  logic [LO_W-1:0]   lo,
  input  logic [HI_W-1:0]   hi,
  input  logic              delay_slot,
  output logic [ADDR_W-1:0] word_addr,
  output logic              misalign
);
  localparam int EXT_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] disp_short;
  logic [ADDR_W-1:0] disp_long;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] sum;

  generate
    if (SIGNED_DISP) begin : g_sext
      assign disp_short = {{EXT_W{lo[LO_W-1]}}, lo};
    end else begin : g_zext
      assign disp_short = {{EXT_W{1'b0}}, lo};
    end
  endgenerate

  assign disp_long = {hi, lo};

  always_comb begin
    if (delay_slot) begin
      disp = '0;
    end else begin
      case (cnt)
        PFX_ONE: disp = disp_short;
        PFX_TWO: disp = disp_long;
        default: disp = '0;
      endcase
    end
    sum       = base + disp;
    misalign  = |sum[1:0];
    word_addr = {sum[ADDR_W-1:2], 2'b00};
  end
endmodule

// File: rtl/store_addr_unit.sv
module store_addr_unit
  import sau_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter bit SIGNED_DISP = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [15:0]        instr,
  input  logic               delay_slot,
  output logic [2:0]         rs_sel,
  output logic [2:0]         rb_sel,
  input  logic [ADDR_W-1:0]  rs_val,
  input  logic [ADDR_W-1:0]  rb_val,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               misalign_req
);
  localparam int LO_W  = PFX_IMM_W;
  localparam int HI_W  = ADDR_W - LO_W;
  localparam int PAD_W = DATA_W - ADDR_W;

  dec_t              dec;
  pfx_cnt_e          pfx_cnt;
  logic [LO_W-1:0]   pfx_lo;
  logic [HI_W-1:0]   pfx_hi;
  logic [ADDR_W-1:0] word_addr;
  logic              misalign;

  logic              we_n;
  logic              mis_n;
  logic              data_en;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] wdata_n;

  sau_decode u_dec (
    .valid (instr_valid),
    .instr (instr),
    .dec   (dec)
  );

  sau_prefix #(.LO_W(LO_W), .HI_W(HI_W)) u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (instr_valid),
    .is_prefix (dec.is_prefix),
    .imm       (dec.imm),
    .cnt       (pfx_cnt),
    .lo        (pfx_lo),
    .hi        (pfx_hi)
  );

  sau_agen #(.ADDR_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W), .SIGNED_DISP(SIGNED_DISP)) u_agen (
    .base       (rb_val),
    .cnt        (pfx_cnt),
    .lo         (pfx_lo),
    .hi         (pfx_hi),
    .delay_slot (delay_slot),
    .word_addr  (word_addr),
    .misalign   (misalign)
  );

  assign rs_sel = dec.rs;
  assign rb_sel = dec.rb;

  always_comb begin
    we_n    = dec.is_store;
    mis_n   = dec.is_store && misalign;
    data_en = dec.is_store;
    addr_n  = word_addr;
    wdata_n = {{PAD_W{1'b0}}, rs_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we       <= 1'b0;
      misalign_req <= 1'b0;
    end else begin
      mem_we       <= we_n;
      misalign_req <= mis_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (data_en) begin
      mem_addr  <= addr_n;
      mem_wdata <= wdata_n;
    end
  end

  p_write_follows_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[15:10] == ST_MAJOR && instr[6:3] == ST_MINOR) |=> mem_we);

  p_no_spurious_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && instr[15:10] == ST_MAJOR && instr[6:3] == ST_MINOR) |=> !mem_we);

  p_data_zero_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec.is_store |=> (mem_wdata == {{PAD_W{1'b0}}, $past(rs_val)}));

  p_delay_plain_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.is_store && delay_slot) |=>
      (mem_addr == {$past(rb_val[ADDR_W-1:2]), 2'b00}) && (misalign_req == ($past(rb_val[1:0]) != 2'b00)));

  p_no_prefix_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.is_store && pfx_cnt == PFX_NONE) |=> (mem_addr == {$past(rb_val[ADDR_W-1:2]), 2'b00}));

  p_misalign_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_req |-> mem_we);
endmodule

// File: tb/tb_store_addr_unit.sv
module tb_store_addr_unit;
  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [15:0] instr;
  logic        delay_slot;
  logic [23:0] rs_val, rb_val;
  logic [2:0]  rs_sel, rb_sel, rs_sel_s, rb_sel_s;
  logic        we, we_s, mis, mis_s;
  logic [23:0] addr, addr_s;
  logic [31:0] wdata, wdata_s;

  int checks = 0;
  int fails  = 0;

  logic [23:0] regs [8];
  int          m_cnt;
  logic [12:0] m_lo;
  logic [10:0] m_hi;

  store_addr_unit #(.SIGNED_DISP(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .delay_slot(delay_slot), .rs_sel(rs_sel), .rb_sel(rb_sel),
    .rs_val(rs_val), .rb_val(rb_val), .mem_we(we), .mem_addr(addr),
    .mem_wdata(wdata), .misalign_req(mis));

  store_addr_unit #(.SIGNED_DISP(1'b1)) dut_sgn (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .delay_slot(delay_slot), .rs_sel(rs_sel_s), .rb_sel(rb_sel_s),
    .rs_val(rs_val), .rb_val(rb_val), .mem_we(we_s), .mem_addr(addr_s),
    .mem_wdata(wdata_s), .misalign_req(mis_s));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] st(input int rs, input int rb);
    return {6'b001001, rs[2:0], 4'b0011, rb[2:0]};
  endfunction

  function automatic logic [15:0] pf(input logic [12:0] imm);
    return {3'b110, imm};
  endfunction

  function automatic logic [23:0] model_sum(input logic [23:0] base, input bit sgn, input bit ds);
    logic [23:0] d;
    if (ds || m_cnt == 0)   d = 24'd0;
    else if (m_cnt == 1)    d = (sgn && m_lo[12]) ? ({11'h7FF, m_lo}) : {11'd0, m_lo};
    else                    d = {m_hi, m_lo};
    return base + d;
  endfunction

  task automatic step(input bit v, input logic [15:0] ins, input bit ds, input string req);
    bit          is_st;
    logic [23:0] s0, s1;
    is_st = v && ins[15:10] == 6'b001001 && ins[6:3] == 4'b0011;
    s0 = model_sum(regs[ins[2:0]], 1'b0, ds);
    s1 = model_sum(regs[ins[2:0]], 1'b1, ds);
    instr_valid = v; instr = ins; delay_slot = ds;
    rs_val = regs[ins[9:7]]; rb_val = regs[ins[2:0]];
    #1;
    if (is_st) begin
      check("R1 rs_sel", {29'd0, rs_sel}, {29'd0, ins[9:7]});
      check("R1 rb_sel", {29'd0, rb_sel}, {29'd0, ins[2:0]});
    end
    @(posedge clk); @(negedge clk);
    check({req, " we"}, {31'd0, we}, {31'd0, is_st});
    check({req, " we sgn"}, {31'd0, we_s}, {31'd0, is_st});
    check({req, " misalign"}, {31'd0, mis}, {31'd0, is_st && s0[1:0] != 0});
    check({req, " misalign sgn"}, {31'd0, mis_s}, {31'd0, is_st && s1[1:0] != 0});
    if (is_st) begin
      check({req, " addr"}, {8'd0, addr}, {8'd0, s0[23:2], 2'b00});
      check({req, " addr sgn"}, {8'd0, addr_s}, {8'd0, s1[23:2], 2'b00});
      check("R5 wdata", wdata, {8'h00, regs[ins[9:7]]});
      check("R5 wdata sgn", wdata_s, {8'h00, regs[ins[9:7]]});
    end
    if (v) begin
      if (ins[15:13] == 3'b110) begin
        m_hi = m_lo[10:0]; m_lo = ins[12:0]; m_cnt = (m_cnt == 0) ? 1 : 2;
      end else begin
        m_cnt = 0; m_lo = '0; m_hi = '0;
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    regs[0] = 24'h000100; regs[1] = 24'hABCDEF; regs[2] = 24'h001000; regs[3] = 24'h000103;
    regs[4] = 24'hFFFFF0; regs[5] = 24'h123456; regs[6] = 24'h800000; regs[7] = 24'h7FFFFC;
    m_cnt = 0; m_lo = '0; m_hi = '0;
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; delay_slot = 1'b0; rs_val = '0; rb_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset we", {31'd0, we}, 32'd0);
    check("R11 reset misalign", {31'd0, mis}, 32'd0);
    rst_n = 1'b1;
    // R11: empty prefix state shows as plain base address
    step(1, st(1, 2), 0, "R11");
    step(1, st(5, 6), 0, "R2");
    step(1, pf(13'h0010), 0, "R9");
    step(1, st(1, 2), 0, "R3");
    // R3: bit 12 set, zero vs sign extension
    step(1, pf(13'h1FFC), 0, "R9");
    step(1, st(5, 0), 0, "R3");
    step(1, pf(13'h07FF), 0, "R9");
    step(1, pf(13'h0004), 0, "R9");
    step(1, st(1, 2), 0, "R4");
    // R9: three prefixes, last two count
    step(1, pf(13'h0001), 0, "R9");
    step(1, pf(13'h0002), 0, "R9");
    step(1, pf(13'h0008), 0, "R9");
    step(1, st(7, 2), 0, "R9");
    // R4: wrap modulo 2^24
    step(1, pf(13'h0020), 0, "R9");
    step(1, st(1, 4), 0, "R4");
    step(1, pf(13'h1000), 0, "R9");
    step(1, pf(13'h0000), 0, "R9");
    step(1, st(1, 6), 0, "R4");
    // R6: misaligned base and misaligned displacement
    step(1, st(1, 3), 0, "R6");
    step(1, pf(13'h0001), 0, "R9");
    step(1, st(1, 0), 0, "R6");
    // R7: delay slot ignores prefix, then prefix is gone
    step(1, pf(13'h0040), 0, "R9");
    step(1, st(1, 2), 1, "R7");
    step(1, st(1, 2), 0, "R7");
    // R8: other instruction consumes prefix
    step(1, pf(13'h0040), 0, "R9");
    step(1, 16'h0001, 0, "R8");
    step(1, st(1, 2), 0, "R8");
    // R8/R10: invalid cycle neither writes nor disturbs prefix
    step(1, pf(13'h0010), 0, "R9");
    step(0, st(1, 2), 0, "R10");
    step(1, st(1, 2), 0, "R8");
    // R1: near-miss opcode does not write, still consumes prefix
    step(1, pf(13'h0100), 0, "R9");
    step(1, {6'b001001, 3'd1, 4'b0010, 3'd2}, 0, "R1");
    step(1, st(1, 2), 0, "R1");
    step(0, 16'h0000, 0, "R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule